// File: doc/BRIEF.md
# Wait-State Word Memory Slave for a Single-Master AHB-Lite Bus

This block is a bus slave that puts a small on-chip word memory behind a single-master AHB-Lite bus. The bus is pipelined. The slave samples address and control while the previous transfer is still in its data phase. It takes a transfer only when it is selected, the bus ready input is high and the transfer code is NONSEQ or SEQ. Reads return the stored word on the read bus. Writes store the lanes of the write bus that the transfer's size and low address bits select.

A parameter sets a fixed number of wait states, from 0 to 3, for every accepted transfer. During those cycles the slave holds its ready output low. This lengthens the current data phase and also holds the next transfer's address phase. An access outside the memory window gets the two-cycle ERROR response and leaves the memory unchanged.

Top module: `ahbl_wait_mem`

## Requirements
- R1: While reset (active low, synchronous) is asserted and in the first cycle after it, hreadyout is 1, hresp is 0 and hrdata is 0.
- R2: A cycle with htrans IDLE (00) or BUSY (01), or with hsel low, starts no transfer. The following cycle shows hreadyout=1, hresp=0 (OKAY) and hrdata=0, and the memory is not written, even when hwrite is 1.
- R3: A NONSEQ (10) or SEQ (11) transfer is taken only in a cycle where hready is high. A transfer presented while hready is held low elsewhere is not taken, and the following cycle is a zero-wait OKAY cycle.
- R4: An accepted in-range transfer has a data phase of exactly WAIT_CYC cycles with hreadyout=0 and hresp=0, followed by one cycle with hreadyout=1 and hresp=0.
- R5: hrdata carries the addressed word only in the final cycle of a read data phase. In every other cycle it is 0.
- R6: A write (hwrite=1) stores hwdata as it stands in the final data-phase cycle. Master-side hwdata is held for the whole data phase.
- R7: The byte lanes written are little-endian, and lane k is hwdata[8k+7:8k]. hsize 000 writes the single lane haddr[1:0]. hsize 001 writes lanes 1:0 when haddr[1]=0 and lanes 3:2 when haddr[1]=1. hsize 010 writes all four lanes.
- R8: A transfer whose address lies outside [BASE_ADDR, BASE_ADDR + 4*MEM_WORDS) gets a two-cycle ERROR response with no wait states. The first cycle has hreadyout=0 and hresp=1, the second has hreadyout=1 and hresp=1. The memory is not written.
- R9: Back-to-back transfers are pipelined. The next transfer is sampled in the final cycle of the current data phase, so each transfer gets its full response with no lost or duplicated beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Synchronous reset, active low |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | 32 | Byte address of the address phase |
| htrans | input | 2 | Transfer code: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size: byte, halfword, word |
| hwdata | input | DATA_W | Write data of the current data phase |
| hready | input | 1 | Bus-level ready; the previous transfer ends |
| hreadyout | output | 1 | This slave's ready for its data phase |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| hrdata | output | DATA_W | Read data, valid in the final read cycle |

## Verification
The hardest case to reach from the ports is an address phase that arrives while the bus ready is low because another slave is stalling. This slave has no data phase of its own in that cycle, so it must ignore the request and still answer OKAY. The bench models that outside stall by pulling hready low at random in cycles where the slave is idle. It mixes these stalls with random back-to-back reads, sized writes, ignored IDLE and BUSY codes and out-of-window addresses. A final sweep reads back every word, which exposes any write that should have been suppressed.

// File: rtl/ahbl_mem_pkg.sv
package ahbl_mem_pkg;

   localparam int LANES = 4;

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } htrans_e;

   typedef enum logic [2:0] {
      RS_IDLE = 3'd0,
      RS_WAIT = 3'd1,
      RS_LAST = 3'd2,
      RS_ERR1 = 3'd3,
      RS_ERR2 = 3'd4
   } resp_st_e;

endpackage

// File: rtl/ahbl_lane_dec.sv
module ahbl_lane_dec
   import ahbl_mem_pkg::*;
(
   input  logic [2:0]       size,
   input  logic [1:0]       lo,
   output logic [LANES-1:0] strb
);

   always_comb begin
      case (size)
         3'b000:  strb = 4'b0001 << lo;
         3'b001:  strb = lo[1] ? 4'b1100 : 4'b0011;
         default: strb = 4'b1111;
      endcase
   end

   // R7
   always_comb begin
      if (size <= 3'd2) begin
         lane_cnt_chk: assert ($countones(strb) == (1 << size))
            else $error("lane strobe count does not match size");
      end
   end

endmodule

// File: rtl/ahbl_resp_fsm.sv
module ahbl_resp_fsm
   import ahbl_mem_pkg::*;
#(
   parameter int WAIT_CYC = 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_err,
   output logic take,
   output logic rdy,
   output logic err,
   output logic last
);

   localparam int       CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
   localparam resp_st_e FIRST = (WAIT_CYC == 0) ? RS_LAST : RS_WAIT;

   resp_st_e st, st_n;
   logic     cnt_zero;
   logic     phase_end;

   assign phase_end = (st == RS_IDLE) || (st == RS_LAST) || (st == RS_ERR2);
   assign take      = start && phase_end;

   generate
      if (WAIT_CYC == 0) begin : g_nowait
         assign cnt_zero = 1'b1;
      end else begin : g_wait
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                         cnt <= '0;
            else if (take)                      cnt <= CNT_W'(WAIT_CYC - 1);
            else if (st == RS_WAIT && cnt != 0) cnt <= cnt - 1'b1;
         end
         assign cnt_zero = (cnt == '0);
      end
   endgenerate

   always_comb begin
      case (st)
         RS_WAIT: st_n = cnt_zero ? RS_LAST : RS_WAIT;
         RS_ERR1: st_n = RS_ERR2;
         default: st_n = take ? (start_err ? RS_ERR1 : FIRST) : RS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= RS_IDLE;
      else        st <= st_n;
   end

   assign rdy  = phase_end;
   assign err  = (st == RS_ERR1) || (st == RS_ERR2);
   assign last = (st == RS_LAST);

   // consecutive OKAY wait cycles, for the bound check
   logic [2:0] run;
   always_ff @(posedge clk) begin
      if (!rst_n)            run <= '0;
      else if (!rdy && !err) run <= run + 3'd1;
      else                   run <= '0;
   end

   // R1
   rst_chk: assert property (@(posedge clk) !rst_n |=> (rdy && !err))
      else $error("slave not idle after reset");

   // R8
   err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !rdy) |=> (err && rdy))
      else $error("error response not two cycles");

   // R4
   wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run <= 3'(WAIT_CYC))
      else $error("too many wait states");

endmodule

// File: rtl/ahbl_word_ram.sv
module ahbl_word_ram
   import ahbl_mem_pkg::*;
#(
   parameter int WORDS = 64,
   parameter int IDX_W = $clog2(WORDS)
)(
   input  logic               clk,
   input  logic               we,
   input  logic [LANES-1:0]   strb,
   input  logic [IDX_W-1:0]   idx,
   input  logic [8*LANES-1:0] wdata,
   output logic [8*LANES-1:0] rdata
);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [7:0] bank [WORDS];
         always_ff @(posedge clk) begin
            if (we && strb[l]) bank[idx] <= wdata[8*l +: 8];
         end
         assign rdata[8*l +: 8] = bank[idx];
      end
   endgenerate

endmodule

// File: rtl/ahbl_wait_mem.sv
module ahbl_wait_mem
   import ahbl_mem_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          MEM_WORDS = 64,
   parameter int          WAIT_CYC  = 1,
   parameter logic [31:0] BASE_ADDR = 32'h0000_0000
)(
   input  logic              hclk,
   input  logic              hresetn,
   input  logic              hsel,
   input  logic [31:0]       haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [2:0]        hsize,
   input  logic [DATA_W-1:0] hwdata,
   input  logic              hready,
   output logic              hreadyout,
   output logic              hresp,
   output logic [DATA_W-1:0] hrdata
);

   localparam int IDX_W     = $clog2(MEM_WORDS);
   localparam int MEM_BYTES = MEM_WORDS * LANES;

   generate
      if (DATA_W != 8 * LANES) begin : g_bad_width
         $error("DATA_W must equal 32");
      end
      if (WAIT_CYC < 0 || WAIT_CYC > 3) begin : g_bad_wait
         $error("WAIT_CYC must lie in 0..3");
      end
      if (MEM_WORDS < 2 || (MEM_WORDS & (MEM_WORDS - 1)) != 0) begin : g_bad_depth
         $error("MEM_WORDS must be a power of two of at least 2");
      end
   endgenerate

   logic [31:0]       off;
   logic              out_rng;
   logic              take;
   logic              phase_last;
   logic [LANES-1:0]  strb_a;
   logic              pend_write;
   logic [IDX_W-1:0]  pend_idx;
   logic [LANES-1:0]  pend_strb;
   logic [DATA_W-1:0] rd_word;

   assign off     = haddr - BASE_ADDR;
   assign out_rng = (haddr < BASE_ADDR) || (off >= 32'(MEM_BYTES));

   ahbl_lane_dec u_lane (
      .size (hsize),
      .lo   (haddr[1:0]),
      .strb (strb_a)
   );

   ahbl_resp_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
      .clk       (hclk),
      .rst_n     (hresetn),
      .start     (hsel && hready && htrans[1]),
      .start_err (out_rng),
      .take      (take),
      .rdy       (hreadyout),
      .err       (hresp),
      .last      (phase_last)
   );

   always_ff @(posedge hclk) begin
      if (!hresetn) begin
         pend_write <= 1'b0;
         pend_idx   <= '0;
         pend_strb  <= '0;
      end else if (take) begin
         pend_write <= hwrite && !out_rng;
         pend_idx   <= off[IDX_W+1:2];
         pend_strb  <= strb_a;
      end
   end

   ahbl_word_ram #(.WORDS(MEM_WORDS), .IDX_W(IDX_W)) u_ram (
      .clk   (hclk),
      .we    (phase_last && pend_write),
      .strb  (pend_strb),
      .idx   (pend_idx),
      .wdata (hwdata),
      .rdata (rd_word)
   );

   assign hrdata = (phase_last && !pend_write) ? rd_word : '0;

   // R2
   noxfer_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (hready && !(hsel && htrans[1])) |=> (hreadyout && !hresp))
      else $error("ignored cycle did not give zero-wait OKAY");

   // R5
   rdata_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (hrdata != '0) |-> (hreadyout && !hresp))
      else $error("read data outside final read cycle");

endmodule

// File: tb/test_ahbl_wait_mem.sv
`timescale 1ns/1ps
module test_ahbl_wait_mem;

   localparam int WAIT  = 1;
   localparam int WORDS = 64;
   localparam int BYTES = WORDS * 4;
   localparam int NT    = 2700;

   typedef struct packed {
      logic        sel;
      logic [1:0]  tr;
      logic        wr;
      logic [2:0]  sz;
      logic [31:0] ad;
      logic [31:0] wd;
   } xfer_t;

   logic        hclk = 1'b0;
   logic        hresetn;
   logic        hreadyout, hresp, hready;
   logic [31:0] hrdata;
   logic [31:0] wdat;
   logic        stall;
   xfer_t       ap, dp;
   xfer_t       tq [NT];
   logic [31:0] mem_m [WORDS];
   int          total = 0, bad = 0;
   int          nxt, wcnt, fill;
   logic        taken, prev_stall;

   always #2.5 hclk = ~hclk;

   assign hready = hreadyout && !stall;

   ahbl_wait_mem #(.DATA_W(32), .MEM_WORDS(WORDS), .WAIT_CYC(WAIT)) i_ahbl_wait_mem (
      .hclk      (hclk),
      .hresetn   (hresetn),
      .hsel      (ap.sel),
      .haddr     (ap.ad),
      .htrans    (ap.tr),
      .hwrite    (ap.wr),
      .hsize     (ap.sz),
      .hwdata    (wdat),
      .hready    (hready),
      .hreadyout (hreadyout),
      .hresp     (hresp),
      .hrdata    (hrdata)
   );

   function automatic xfer_t mk(logic sel, logic [1:0] tr, logic wr, logic [2:0] sz,
                                logic [31:0] ad, logic [31:0] wd);
      xfer_t x;
      x.sel = sel; x.tr = tr; x.wr = wr; x.sz = sz; x.ad = ad; x.wd = wd;
      return x;
   endfunction

   function automatic logic is_real(xfer_t x);
      return x.sel && x.tr[1];
   endfunction

   function automatic logic is_err(xfer_t x);
      return x.ad >= 32'(BYTES);
   endfunction

   // R7: lane mask from size and low address bits
   function automatic logic [3:0] lanes_of(logic [2:0] sz, logic [1:0] lo);
      if (sz == 3'b000) return 4'b0001 << lo;
      if (sz == 3'b001) return lo[1] ? 4'b1100 : 4'b0011;
      return 4'b1111;
   endfunction

   task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic push(xfer_t x);
      if (fill < NT) begin
         tq[fill] = x;
         fill++;
      end
   endtask

   task automatic build();
      fill = 0;
      // fill every word so later reads have known contents
      for (int i = 0; i < WORDS; i++)
         push(mk(1, (i == 0) ? 2'b10 : 2'b11, 1, 3'b010, 32'(i * 4), $urandom));
      // R7 byte lanes of word 5, then read back
      for (int l = 0; l < 4; l++)
         push(mk(1, 2'b10, 1, 3'b000, 32'(20 + l), 32'h11223344 * 32'(l + 1)));
      push(mk(1, 2'b10, 0, 3'b010, 32'd20, 32'h0));
      // R7 halfwords of word 6
      push(mk(1, 2'b10, 1, 3'b001, 32'd24, 32'hAAAA_5555));
      push(mk(1, 2'b10, 1, 3'b001, 32'd26, 32'h1234_9876));
      push(mk(1, 2'b10, 0, 3'b010, 32'd24, 32'h0));
      // R8 first address past the window, read and write; last valid word
      push(mk(1, 2'b10, 0, 3'b010, 32'(BYTES), 32'h0));
      push(mk(1, 2'b10, 1, 3'b010, 32'(BYTES), 32'hDEAD_BEEF));
      push(mk(1, 2'b10, 0, 3'b010, 32'(BYTES - 4), 32'h0));
      // R2 IDLE, BUSY and deselected writes to word 7, then read it
      push(mk(1, 2'b00, 1, 3'b010, 32'd28, 32'hFFFF_FFFF));
      push(mk(1, 2'b01, 1, 3'b010, 32'd28, 32'hFFFF_FFFF));
      push(mk(0, 2'b10, 1, 3'b010, 32'd28, 32'hFFFF_FFFF));
      push(mk(1, 2'b10, 0, 3'b010, 32'd28, 32'h0));
      // random mix
      while (fill < NT - WORDS) begin
         int r;
         logic [2:0] sz;
         logic [1:0] lo;
         r  = int'($urandom % 100);
         sz = 3'($urandom % 3);
         lo = (sz == 3'b000) ? 2'($urandom % 4) : (sz == 3'b001) ? 2'(($urandom % 2) * 2) : 2'b00;
         if (r < 10)      push(mk(1, 2'b00, 1'($urandom), sz, $urandom % BYTES, $urandom));
         else if (r < 18) push(mk(1, 2'b01, 1'($urandom), sz, $urandom % BYTES, $urandom));
         else if (r < 23) push(mk(0, 2'b10, 1'($urandom), sz, $urandom % BYTES, $urandom));
         else if (r < 33) push(mk(1, 2'b10, 1'($urandom), 3'b010,
                                  32'(BYTES) + 32'(($urandom % 4096) * 4), $urandom));
         else             push(mk(1, {1'b1, 1'($urandom)}, 1'($urandom), sz,
                                  32'(($urandom % WORDS) * 4) + 32'(lo), $urandom));
      end
      // final sweep: read back every word
      for (int i = 0; i < WORDS; i++)
         push(mk(1, 2'b10, 0, 3'b010, 32'(i * 4), 32'h0));
   endtask

   task automatic check_cycle();
      logic [1:0] exp_rr;
      if (!is_real(dp)) begin
         chk({hreadyout, hresp} == 2'b10 && hrdata == '0, prev_stall ? "R3" : "R2",
             {hreadyout, hresp, hrdata[29:0]}, 32'h8000_0000);
      end else if (is_err(dp)) begin
         exp_rr = (wcnt == 0) ? 2'b01 : 2'b11;
         chk({hreadyout, hresp} == exp_rr && hrdata == '0, "R8",
             {30'd0, hreadyout, hresp}, {30'd0, exp_rr});
      end else begin
         exp_rr = (wcnt == WAIT) ? 2'b10 : 2'b00;
         chk({hreadyout, hresp} == exp_rr, "R4 R9", {30'd0, hreadyout, hresp}, {30'd0, exp_rr});
         if (wcnt == WAIT && !dp.wr)
            chk(hrdata == mem_m[dp.ad[7:2]], "R5 R6 R7", hrdata, mem_m[dp.ad[7:2]]);
         else
            chk(hrdata == '0, "R5", hrdata, 32'h0);
      end
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge hclk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      build();
      ap      = mk(0, 2'b00, 0, 3'b010, 32'h0, 32'h0);
      wdat    = '0;
      stall   = 1'b0;
      hresetn = 1'b0;
      repeat (4) @(posedge hclk);
      @(negedge hclk);
      // R1
      chk({hreadyout, hresp} == 2'b10 && hrdata == '0, "R1", {30'd0, hreadyout, hresp}, 32'h2);
      hresetn    = 1'b1;
      dp         = mk(0, 2'b00, 0, 3'b010, 32'h0, 32'h0);
      wcnt       = 0;
      prev_stall = 1'b0;
      ap         = tq[0];
      nxt        = 1;
      taken      = 1'b1;
      while (nxt < NT + 3) begin
         @(negedge hclk);
         if (taken) begin
            dp   = ap;
            wcnt = 0;
            wdat = dp.wd;
            ap   = (nxt < NT) ? tq[nxt] : mk(1, 2'b00, 0, 3'b010, 32'h0, 32'h0);
            nxt++;
         end
         check_cycle();
         if (hreadyout && is_real(dp) && !is_err(dp) && dp.wr) begin
            logic [3:0] m;
            m = lanes_of(dp.sz, dp.ad[1:0]);
            for (int l = 0; l < 4; l++)
               if (m[l]) mem_m[dp.ad[7:2]][8*l +: 8] = dp.wd[8*l +: 8];
         end
         prev_stall = stall;
         stall      = !is_real(dp) && ($urandom % 6 == 0);
         taken      = hreadyout && !stall;
         wcnt++;
      end
      report();
      $finish;
   end

endmodule